// File: doc/BRIEF.md
# Buck Soft-Start and Fault Sequencer

This block is the supervisory state machine of a voltage-mode synchronous buck controller. It takes already-digitised comparator flags (supply good, over-current trip, feedback under-voltage, feedback over-voltage and shutdown request). From them it produces a reference code for the error amplifier, a PWM inhibit, a request to hold the low-side switch on, and status flags. During start-up the reference is replaced by a digital ramp that climbs from zero to the regulation code. After that the block runs normally until a fault or a shutdown request moves it into one of its off states.

Over-current and under-voltage are recovered in different ways. An over-current trip stops switching for one cycle and restarts the soft-start ramp. Trips are counted, and the fourth one turns the output off for good, with both gates low. An under-voltage in normal operation starts a fixed hiccup wait, timed from the moment of shutdown, and then a new soft-start. Under-voltage never latches and is ignored while the ramp is running. The ramp timing and the hiccup wait are parameters in clock cycles. With the defaults the soft-start takes 101 cycles and the hiccup wait takes 150 cycles, which stands for the millisecond intervals on a scaled test clock.

Top module: `buck_fault_seq`

## Requirements
- R1: While supply_ok_i is low the state is RESET (code 0) on the next cycle and the over-current count is 0. With supply_ok_i high and shdn_i low, RESET moves to SOFTSTART (code 1) on the next clock.
- R2: In SOFTSTART, ref_code_o starts at 0 on the first cycle and rises by RAMP_STEP every SS_DIV cycles, capped at REF_CODE. The state moves to RUN (code 2) on the clock after the ramp reaches REF_CODE. In RUN, ref_code_o equals REF_CODE.
- R3: An over-current trip in SOFTSTART or RUN, when fewer than OC_LIMIT-1 trips have been counted, increments the count. It then enters OC_OFF (code 3) for one cycle, followed by a new SOFTSTART whose ramp starts again from 0.
- R4: The trip that brings the count to OC_LIMIT (default 4) enters LATCHED (code 5). LATCHED stays put while supply is good and shutdown is low, whatever the fault inputs do.
- R5: The over-current count saturates at OC_LIMIT. A completed soft-start does not clear it. Only shutdown or loss of supply clears it.
- R6: fb_under_i in RUN enters UV_HICCUP (code 4). The block stays there exactly HICCUP_CYCLES cycles, then enters SOFTSTART. This can repeat without limit and leaves the over-current count unchanged.
- R7: fb_under_i has no effect during SOFTSTART.
- R8: In SOFTSTART or RUN, fb_over_i drives force_low_o and pwm_inhibit_o high in the same cycle. Both drop when fb_over_i drops, and fb_over_i does not change the state.
- R9: shdn_i high, with supply good, enters SHUTDOWN (code 6) on the next cycle and clears the count, even from LATCHED. Releasing shdn_i gives SOFTSTART on the next clock.
- R10: In every state other than SOFTSTART and RUN, pwm_inhibit_o is 1, force_low_o is 0 (both gates off) and ref_code_o is 0. ss_active_o is high only in SOFTSTART and latched_o only in LATCHED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above power-on threshold |
| oc_trip_i | input | 1 | Over-current comparator trip |
| fb_under_i | input | 1 | Feedback below under-voltage threshold |
| fb_over_i | input | 1 | Feedback above over-voltage threshold |
| shdn_i | input | 1 | External shutdown request |
| ref_code_o | output | CODE_W | Reference code (ramp during soft-start) |
| pwm_inhibit_o | output | 1 | Suppress high-side pulses |
| force_low_o | output | 1 | Hold low-side switch on |
| ss_active_o | output | 1 | Soft-start in progress |
| latched_o | output | 1 | Latched off after over-current limit |
| oc_count_o | output | OC_W | Over-current events counted |
| state_o | output | 3 | Current state code |

## Verification
State, count and ramp code are registered, so a flag present at one clock edge shows its effect on state_o, oc_count_o and ref_code_o one edge later. pwm_inhibit_o and force_low_o follow fb_over_i within the same cycle. The bench drives inputs just after a falling edge and updates a behavioural model on each rising edge. It then compares every output against the model at the next falling edge, so each registered result is checked in the cycle after its cause and each combinational result in the cycle it is driven. The stimulus covers the full 101-cycle ramp, the 150-cycle hiccup wait counted from the fault, trips both in mid-ramp and in RUN, and shutdown releasing a latched block.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_SOFT    = 3'd1,
    ST_RUN     = 3'd2,
    ST_OC_OFF  = 3'd3,
    ST_UV_WAIT = 3'd4,
    ST_LATCH   = 3'd5,
    ST_SHUT    = 3'd6
  } seq_state_e;
endpackage

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen #(
  parameter int CODE_W    = 8,
  parameter int REF_CODE  = 100,
  parameter int RAMP_STEP = 4,
  parameter int SS_DIV    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  localparam int DIV_W = (SS_DIV > 1) ? $clog2(SS_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SS_DIV - 1);
  localparam logic [CODE_W:0]  REF_X    = (CODE_W+1)'(REF_CODE);
  localparam logic [CODE_W:0]  STEP_X   = (CODE_W+1)'(RAMP_STEP);

  logic [DIV_W-1:0]  pre_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W:0]   sum;
  logic              tick;

  assign tick   = (pre_q == DIV_LAST);
  assign sum    = {1'b0, code_q} + STEP_X;
  assign done_o = ({1'b0, code_q} >= REF_X);
  assign code_o = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      code_q <= '0;
    end else if (!run_i) begin
      pre_q  <= '0;
      code_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick && !done_o)
        code_q <= (sum >= REF_X) ? REF_X[CODE_W-1:0] : sum[CODE_W-1:0];
    end
  end

  assert_ramp_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, code_q} <= REF_X);
  assert_ramp_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && !done_o) |=> (!run_i || code_q > $past(code_q)));
endmodule

// File: rtl/oc_event_tally.sv
module oc_event_tally #(
  parameter int OC_LIMIT = 4,
  parameter int CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(OC_LIMIT);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OC_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MAX_C) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_C);

  assert_oc_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C);
  assert_oc_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_oc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hiccup_timer.sv
module hiccup_timer #(
  parameter int HICCUP_CYCLES = 150,
  parameter int CNT_W         = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(HICCUP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end

  assert_hic_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_C);
  assert_hic_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/buck_fault_seq.sv
module buck_fault_seq
  import buck_seq_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int REF_CODE      = 100,
  parameter int RAMP_STEP     = 4,
  parameter int SS_DIV        = 4,
  parameter int HICCUP_CYCLES = 150,
  parameter int OC_LIMIT      = 4,
  localparam int OC_W         = $clog2(OC_LIMIT + 1),
  localparam int HIC_W        = $clog2(HICCUP_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic              oc_trip_i,
  input  logic              fb_under_i,
  input  logic              fb_over_i,
  input  logic              shdn_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              pwm_inhibit_o,
  output logic              force_low_o,
  output logic              ss_active_o,
  output logic              latched_o,
  output logic [OC_W-1:0]   oc_count_o,
  output logic [2:0]        state_o
);
  localparam logic [CODE_W-1:0] REF_C = CODE_W'(REF_CODE);

  seq_state_e        state_q, state_d;
  logic              oc_evt, oc_last, ss_done, hic_expire, active;
  logic [CODE_W-1:0] ramp_code;

  ss_ramp_gen #(.CODE_W(CODE_W), .REF_CODE(REF_CODE), .RAMP_STEP(RAMP_STEP), .SS_DIV(SS_DIV))
    u_ramp (.clk_i, .rst_ni, .run_i(state_q == ST_SOFT), .code_o(ramp_code), .done_o(ss_done));

  oc_event_tally #(.OC_LIMIT(OC_LIMIT), .CNT_W(OC_W))
    u_oc (.clk_i, .rst_ni, .clr_i(!supply_ok_i || shdn_i), .inc_i(oc_evt),
          .cnt_o(oc_count_o), .last_o(oc_last));

  hiccup_timer #(.HICCUP_CYCLES(HICCUP_CYCLES), .CNT_W(HIC_W))
    u_hic (.clk_i, .rst_ni, .run_i(state_q == ST_UV_WAIT), .expire_o(hic_expire));

  // priority: supply loss, then shutdown, then per-state faults
  always_comb begin
    state_d = state_q;
    oc_evt  = 1'b0;
    if (!supply_ok_i)  state_d = ST_RESET;
    else if (shdn_i)   state_d = ST_SHUT;
    else begin
      unique case (state_q)
        ST_RESET, ST_OC_OFF, ST_SHUT: state_d = ST_SOFT;
        ST_SOFT, ST_RUN: begin
          if (oc_trip_i) begin
            oc_evt  = 1'b1;
            state_d = oc_last ? ST_LATCH : ST_OC_OFF;
          end else if (state_q == ST_SOFT) begin
            if (ss_done) state_d = ST_RUN;
          end else if (fb_under_i) begin
            state_d = ST_UV_WAIT;
          end
        end
        ST_UV_WAIT: if (hic_expire) state_d = ST_SOFT;
        ST_LATCH:   state_d = ST_LATCH;
        default:    state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign active        = (state_q == ST_SOFT) || (state_q == ST_RUN);
  assign pwm_inhibit_o = !active || fb_over_i;
  assign force_low_o   = active && fb_over_i;
  assign ref_code_o    = (state_q == ST_SOFT) ? ramp_code :
                         (state_q == ST_RUN)  ? REF_C : '0;
  assign ss_active_o   = (state_q == ST_SOFT);
  assign latched_o     = (state_q == ST_LATCH);
  assign state_o       = state_q;

  assert_reset_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (state_q == ST_RESET && oc_count_o == '0));
  assert_latch_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH && supply_ok_i && !shdn_i) |=> (state_q == ST_LATCH));
  assert_uv_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOFT) |=> (state_q != ST_UV_WAIT));
  assert_ov_keeps_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && fb_over_i && supply_ok_i && !shdn_i && !oc_trip_i && !fb_under_i)
      |=> (state_q == ST_RUN));
  assert_shutdown_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_ok_i && shdn_i) |=> (state_q == ST_SHUT && oc_count_o == '0));
  assert_oc_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OC_OFF && supply_ok_i && !shdn_i) |=> (state_q == ST_SOFT && ref_code_o == '0));
endmodule

// File: tb/sim_buck_fault_seq.sv
`timescale 1ns/1ps
module sim_buck_fault_seq;
  localparam int REF = 100, STEP = 4, DIV = 4, HIC = 150, OCL = 4;
  localparam int S_RESET = 0, S_SOFT = 1, S_RUN = 2, S_OCOFF = 3, S_UV = 4, S_LATCH = 5, S_SHUT = 6;

  logic clk = 0, rst_n = 0;
  logic sg = 0, oc = 0, uv = 0, ov = 0, sd = 0;
  logic [7:0] ref_code;
  logic inh, fl, ssa, lat;
  logic [2:0] occ, st;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  buck_fault_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sg), .oc_trip_i(oc), .fb_under_i(uv),
    .fb_over_i(ov), .shdn_i(sd), .ref_code_o(ref_code), .pwm_inhibit_o(inh),
    .force_low_o(fl), .ss_active_o(ssa), .latched_o(lat), .oc_count_o(occ), .state_o(st));

  // behavioural reference model
  int m_st = S_RESET, m_k = 0, m_h = 0, m_oc = 0;

  function automatic int ramp_of(int k);
    int r = (k / DIV) * STEP;
    return (r > REF) ? REF : r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = S_RESET; m_oc = 0; m_k = 0; m_h = 0;
    end else if (!sg) begin
      m_st = S_RESET; m_oc = 0;
    end else if (sd) begin
      m_st = S_SHUT; m_oc = 0;
    end else begin
      case (m_st)
        S_RESET, S_OCOFF, S_SHUT: begin m_st = S_SOFT; m_k = 0; end
        S_SOFT, S_RUN: begin
          if (oc) begin
            m_oc = m_oc + 1;
            m_st = (m_oc == OCL) ? S_LATCH : S_OCOFF;
          end else if (m_st == S_SOFT) begin
            if (ramp_of(m_k) >= REF) m_st = S_RUN;
            else m_k++;
          end else if (uv) begin
            m_st = S_UV; m_h = 0;
          end
        end
        S_UV: if (m_h == HIC - 1) begin m_st = S_SOFT; m_k = 0; end else m_h++;
        default: ;
      endcase
    end
  end

  function automatic string tag_of();
    case (m_st)
      S_RESET: return "R1";
      S_SOFT:  return ov ? "R8" : (uv ? "R7" : "R2");
      S_RUN:   return ov ? "R8" : "R2";
      S_OCOFF: return "R3";
      S_UV:    return "R6";
      S_LATCH: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit act_st = (m_st == S_SOFT) || (m_st == S_RUN);
    int e_ref = (m_st == S_SOFT) ? ramp_of(m_k) : (m_st == S_RUN) ? REF : 0;
    string t = tag_of();
    chk(t, "state", int'(st), m_st);
    chk(t, "ref_code", int'(ref_code), e_ref);
    chk(act_st ? "R8" : "R10", "pwm_inhibit", int'(inh), int'(!act_st || ov));
    chk(act_st ? "R8" : "R10", "force_low", int'(fl), int'(act_st && ov));
    chk("R10", "ss_active", int'(ssa), int'(m_st == S_SOFT));
    chk("R10", "latched", int'(lat), int'(m_st == S_LATCH));
    chk("R5", "oc_count", int'(occ), m_oc);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(5);                          // R1: held in reset without supply
    sg = 1; uv = 1; tick(60);         // R7: under-voltage ignored in ramp
    uv = 0; tick(60);                 // R2: ramp completes, RUN
    ov = 1; tick(3); ov = 0; tick(2); // R8
    uv = 1; tick(1); uv = 0;          // R6: hiccup
    tick(160); tick(110);
    uv = 1; tick(1); uv = 0; tick(60);// R6: second hiccup, no latch
    tick(160);
    oc = 1; tick(1); oc = 0; tick(40);// R3: first trip, ramp restarts
    oc = 1; tick(1); oc = 0; tick(120);// R3: trip mid-ramp
    oc = 1; tick(1); oc = 0; tick(120);// R5: count survives soft-start
    oc = 1; tick(1); oc = 0; tick(5); // R4: fourth trip latches
    oc = 1; uv = 1; ov = 1; tick(5);  // R4/R10: no effect while latched
    oc = 0; uv = 0; ov = 0; tick(3);
    sd = 1; tick(4); sd = 0; tick(120);// R9: shutdown clears latch and count
    oc = 1; tick(1); oc = 0; tick(20);
    sg = 0; tick(3); sg = 1;          // R1/R5: supply loss clears count
    tick(30); ov = 1; tick(2); ov = 0; tick(90);
    sd = 1; tick(2); sg = 0; tick(2); sg = 1; tick(2); sd = 0; tick(10); // R1 over R9
    done = 1;
    finish_run();
  end
endmodule